// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block sits between a small 8-bit processor core and its interrupt controller. It owns the hardware side of taking an interrupt. It waits for an instruction boundary. It then saves the return context on a byte-wide stack in data memory, switches interrupts off and steers the program counter to an 8-bit vector in page zero. When the core executes a return-from-interrupt, the block runs the mirror sequence. That sequence restores the flag register and the program counter from the same stack.

The core supplies its current program counter and flag register. It loads `pc_out` when `pc_load` is high, and `flags_out` when `flags_load` is high. While `busy` is high the core holds fetch and decode. The stack lives in a byte-addressed data memory. Reads from it are combinational: `mem_rdata` follows `mem_addr` in the same cycle. Bit 0 of the flag register is the global interrupt enable. The stack pointer resets to 0x00. It grows upward: a push writes at `sp` and then increments it, and a pop decrements it and reads at the new value.

The state machine has these states: IDLE, PUSH_HI, PUSH_LO, PUSH_FL, VECTOR, ENT_WAIT, POP_FL, POP_LO and POP_HI. Its transitions are:
- IDLE to POP_FL on a return strobe.
- IDLE to PUSH_HI on an accepted request.
- PUSH_HI to PUSH_LO to PUSH_FL to VECTOR to ENT_WAIT, one step per cycle.
- ENT_WAIT back to IDLE when the pad counter reaches zero.
- POP_FL to POP_LO to POP_HI, then back to IDLE.

A one-cycle resume flag is set on leaving POP_HI. It lets the cycle just after a return count as an instruction boundary.

Top module: `irq_seq`

## Requirements
- R1: A request is accepted, shown by `irq_ack` high, only in an IDLE cycle where all of the following hold: `irq_req` is high, `flags_in[0]` is high, `ret_strobe` is low, and either `insn_done` is high or the previous cycle ended a return. No entry starts in any other cycle.
- R2: In the three cycles after acceptance, the block writes three bytes to `mem_addr` = sp, sp+1 and sp+2. The bytes are `pc_in[15:8]`, then `pc_in[7:0]`, then `flags_in`, all as sampled in the acceptance cycle. `sp` ends three higher.
- R3: In the fourth cycle after acceptance, `flags_load` is high with `flags_out` = 0x00. In the same cycle, `pc_load` is high with `pc_out` = {0x00, `irq_vec` sampled at acceptance}.
- R4: `busy` is high for exactly the 13 cycles that follow the acceptance cycle and is low in the 14th.
- R5: A `ret_strobe` in IDLE starts a 3-cycle return with `busy` high. In the first cycle, `flags_load` is high with the byte at sp-1. In the third cycle, `pc_load` is high with {byte at sp-3, byte at sp-2}. `sp` ends three lower.
- R6: When `ret_strobe` and an otherwise acceptable request arrive in the same IDLE cycle, the return runs and the request is not acknowledged.
- R7: In the cycle right after a return completes, an enabled pending request is accepted even with `insn_done` low. One cycle later, a request with `insn_done` low is not accepted.
- R8: If the handler sets `flags_in[0]`, a second request is accepted at the next boundary. The second frame is stacked above the first (sp advances by six in total), and the two returns unwind in reverse order.
- R9: While `busy` is high, `insn_done`, `irq_req`, `ret_strobe` and `irq_vec` have no effect. `irq_ack` stays low, and the pushed bytes, vector and timing are unchanged.
- R10: During and right after reset, `busy`, `irq_ack`, `mem_we`, `pc_load` and `flags_load` are low and `sp` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has fully completed this cycle |
| irq_req | input | 1 | Interrupt controller has an active, enabled request |
| irq_vec | input | 8 | Vector byte for the request |
| irq_ack | output | 1 | Request accepted this cycle |
| ret_strobe | input | 1 | Core has executed a return-from-interrupt |
| pc_in | input | 16 | Core program counter (return address) |
| flags_in | input | 8 | Core flag register, bit 0 is the global enable |
| pc_out | output | 16 | New program counter value |
| pc_load | output | 1 | Core loads `pc_out` this cycle |
| flags_out | output | 8 | New flag register value |
| flags_load | output | 1 | Core loads `flags_out` this cycle |
| sp | output | 8 | Stack pointer |
| mem_addr | output | 8 | Data memory address for push or pop |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte, combinational on `mem_addr` |
| busy | output | 1 | Sequence in progress; core stalls |

## Verification
Entry is first driven with directed patterns that separate each gate of R1: the enable clear, no boundary, and the resume cycle with and without a pending request. Randomized return addresses, flag bytes and vectors then show that the three pushed bytes keep their order and are not simply constants or swapped halves. Random noise on every input while `busy` is high tells a sequencer that truly ignores its inputs from one that restarts or acknowledges. Nested entries and a return that collides with a request test the stack's last-in, first-out order and the return-first priority.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_FL,
        S_VECTOR,
        S_ENT_WAIT,
        S_POP_FL,
        S_POP_LO,
        S_POP_HI
    } seq_state_e;

endpackage

// File: rtl/irq_seq_timer.sv
// Pad counter that stretches entry to its fixed length.
module irq_seq_timer #(
    parameter int W        = 4,
    parameter int LOAD_VAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(LOAD_VAL);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/irq_seq_sp.sv
// Upward-growing stack pointer: write then increment, decrement then read.
module irq_seq_sp #(
    parameter int           W         = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    output logic [W-1:0] sp,
    output logic [W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= RESET_VAL;
        end else if (push) begin
            sp <= sp + W'(1);
        end else if (pop) begin
            sp <= sp - W'(1);
        end
    end

    assign addr = pop ? (sp - W'(1)) : sp;
endmodule

// File: rtl/irq_seq_ctrl.sv
// Sequencing state machine for interrupt entry and return.
module irq_seq_ctrl
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_done,
    input  logic       irq_req,
    input  logic       gie_on,
    input  logic       ret_strobe,
    input  logic       wait_done,
    output seq_state_e state,
    output logic       accept,
    output logic       wait_load
);
    seq_state_e state_d;
    logic       resume_q;
    logic       boundary;

    assign boundary = insn_done || resume_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            resume_q <= 1'b0;
        end else begin
            state    <= state_d;
            resume_q <= (state == S_POP_HI);
        end
    end

    always_comb begin
        state_d   = state;
        accept    = 1'b0;
        wait_load = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ret_strobe) begin
                    state_d = S_POP_FL;
                end else if (boundary && irq_req && gie_on) begin
                    accept  = 1'b1;
                    state_d = S_PUSH_HI;
                end
            end
            S_PUSH_HI:  state_d = S_PUSH_LO;
            S_PUSH_LO:  state_d = S_PUSH_FL;
            S_PUSH_FL:  state_d = S_VECTOR;
            S_VECTOR: begin
                wait_load = 1'b1;
                state_d   = S_ENT_WAIT;
            end
            S_ENT_WAIT: if (wait_done) state_d = S_IDLE;
            S_POP_FL:   state_d = S_POP_LO;
            S_POP_LO:   state_d = S_POP_HI;
            S_POP_HI:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int                ENTRY_CYCLES = 13,
    parameter int                GIE_BIT      = 0,
    parameter logic [BYTE_W-1:0] SP_RESET     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [BYTE_W-1:0] irq_vec,
    output logic              irq_ack,
    input  logic              ret_strobe,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_load,
    output logic [BYTE_W-1:0] flags_out,
    output logic              flags_load,
    output logic [BYTE_W-1:0] sp,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy
);
    // Four cycles are fixed (three pushes plus the vector load); the rest are padding.
    localparam int PAD_LOAD = ENTRY_CYCLES - 5;
    localparam int PAD_W    = $clog2(ENTRY_CYCLES);

    seq_state_e        state;
    logic              accept;
    logic              wait_load;
    logic              wait_done;
    logic              sp_push;
    logic              sp_pop;
    logic [PC_W-1:0]   cap_pc;
    logic [BYTE_W-1:0] cap_fl;
    logic [BYTE_W-1:0] cap_vec;
    logic [BYTE_W-1:0] pop_lo_q;

    irq_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .gie_on    (flags_in[GIE_BIT]),
        .ret_strobe(ret_strobe),
        .wait_done (wait_done),
        .state     (state),
        .accept    (accept),
        .wait_load (wait_load)
    );

    irq_seq_timer #(
        .W       (PAD_W),
        .LOAD_VAL(PAD_LOAD)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wait_load),
        .done (wait_done)
    );

    irq_seq_sp #(
        .W        (BYTE_W),
        .RESET_VAL(SP_RESET)
    ) u_sp (
        .clk  (clk),
        .rst_n(rst_n),
        .push (sp_push),
        .pop  (sp_pop),
        .sp   (sp),
        .addr (mem_addr)
    );

    // Context captured at acceptance; low return byte held between pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pc   <= '0;
            cap_fl   <= '0;
            cap_vec  <= '0;
            pop_lo_q <= '0;
        end else begin
            if (accept) begin
                cap_pc  <= pc_in;
                cap_fl  <= flags_in;
                cap_vec <= irq_vec;
            end
            if (state == S_POP_LO) begin
                pop_lo_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_we     = 1'b0;
        mem_wdata  = '0;
        pc_load    = 1'b0;
        pc_out     = '0;
        flags_load = 1'b0;
        flags_out  = '0;
        sp_push    = 1'b0;
        sp_pop     = 1'b0;
        unique case (state)
            S_PUSH_HI: begin
                mem_we    = 1'b1;
                sp_push   = 1'b1;
                mem_wdata = cap_pc[PC_W-1:BYTE_W];
            end
            S_PUSH_LO: begin
                mem_we    = 1'b1;
                sp_push   = 1'b1;
                mem_wdata = cap_pc[BYTE_W-1:0];
            end
            S_PUSH_FL: begin
                mem_we    = 1'b1;
                sp_push   = 1'b1;
                mem_wdata = cap_fl;
            end
            S_VECTOR: begin
                pc_load    = 1'b1;
                pc_out     = {{BYTE_W{1'b0}}, cap_vec};
                flags_load = 1'b1;
                flags_out  = '0;
            end
            S_POP_FL: begin
                sp_pop     = 1'b1;
                flags_load = 1'b1;
                flags_out  = mem_rdata;
            end
            S_POP_LO: begin
                sp_pop = 1'b1;
            end
            S_POP_HI: begin
                sp_pop  = 1'b1;
                pc_load = 1'b1;
                pc_out  = {mem_rdata, pop_lo_q};
            end
            default: begin
            end
        endcase
    end

    assign irq_ack = accept;
    assign busy    = (state != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int GIE_BIT = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic [7:0]  irq_vec,
    input logic        irq_ack,
    input logic        ret_strobe,
    input logic [15:0] pc_in,
    input logic [7:0]  flags_in,
    input logic [15:0] pc_out,
    input logic        pc_load,
    input logic [7:0]  flags_out,
    input logic        flags_load,
    input logic [7:0]  sp,
    input logic [7:0]  mem_addr,
    input logic        mem_we,
    input logic [7:0]  mem_wdata,
    input logic        busy
);
    p_ack_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_req && flags_in[GIE_BIT] && !ret_strobe));

    p_push_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_we && mem_wdata == $past(pc_in[15:8]) && mem_addr == $past(sp)));

    p_sp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) + 8'd1));

    p_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ##4 (pc_load && flags_load && flags_out == 8'h00
                         && pc_out == {8'h00, $past(irq_vec, 4)}));

    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> busy);

    p_ret_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !busy) |=> (flags_load && !pc_load && !mem_we
                                   && mem_addr == $past(sp) - 8'd1));

    p_ret_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !busy) |-> ##3 (pc_load && sp == $past(sp, 3) - 8'd2));

    p_ret_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !busy) |-> !irq_ack);

    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pc_load) && $past(busy) && !busy && irq_req
         && flags_in[GIE_BIT] && !ret_strobe) |-> irq_ack);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_ack);
endmodule

bind irq_seq irq_seq_chk #(.GIE_BIT(GIE_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .ret_strobe(ret_strobe),
    .pc_in     (pc_in),
    .flags_in  (flags_in),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .flags_out (flags_out),
    .flags_load(flags_load),
    .sp        (sp),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .busy      (busy)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRY      = 13;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic        irq_req = 1'b0;
    logic        ret_strobe = 1'b0;
    logic [7:0]  irq_vec = 8'h00;
    logic        irq_ack;
    logic [15:0] pc_out;
    logic        pc_load;
    logic [7:0]  flags_out;
    logic        flags_load;
    logic [7:0]  sp;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy;

    // Core and data-memory model.
    logic [7:0]  mem [256];
    logic [15:0] core_pc = 16'h0000;
    logic [7:0]  core_fl = 8'h00;
    logic        sw_wr = 1'b0;
    logic [15:0] sw_pc = 16'h0000;
    logic [7:0]  sw_fl = 8'h00;

    // Expected stack contents.
    logic [15:0] stk_pc [32];
    logic [7:0]  stk_fl [32];
    int          depth = 0;
    logic [7:0]  exp_sp = 8'h00;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (sw_wr) begin
            core_pc <= sw_pc;
            core_fl <= sw_fl;
        end else begin
            if (pc_load)    core_pc <= pc_out;
            if (flags_load) core_fl <= flags_out;
        end
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    irq_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_ack   (irq_ack),
        .ret_strobe(ret_strobe),
        .pc_in     (core_pc),
        .flags_in  (core_fl),
        .pc_out    (pc_out),
        .pc_load   (pc_load),
        .flags_out (flags_out),
        .flags_load(flags_load),
        .sp        (sp),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy)
    );

    function automatic logic [15:0] vec_pc(input logic [7:0] v);
        return {8'h00, v};
    endfunction

    function automatic logic [7:0] with_gie(input logic [7:0] f);
        return f | 8'h01;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_core(input logic [15:0] p, input logic [7:0] f);
        sw_pc = p;
        sw_fl = f;
        sw_wr = 1'b1;
        step();
        sw_wr = 1'b0;
    endtask

    // Entry from an IDLE negedge; returns at the negedge of the 14th cycle.
    task automatic run_entry(input logic [7:0] vec, input bit via_resume);
        logic [15:0] p0;
        logic [7:0]  f0;
        logic [7:0]  s0;
        p0 = core_pc;
        f0 = core_fl;
        s0 = exp_sp;
        irq_vec   = vec;
        irq_req   = 1'b1;
        insn_done = !via_resume;
        #1;
        if (via_resume)
            check(irq_ack === 1'b1, "R7 accept in cycle after return", 32'(irq_ack), 32'd1);
        else
            check(irq_ack === 1'b1, "R1 accept at boundary", 32'(irq_ack), 32'd1);
        step();
        irq_req   = 1'b0;
        insn_done = 1'b0;
        for (int k = 1; k <= ENTRY; k++) begin
            check(busy === 1'b1, "R4 busy during entry", 32'(busy), 32'd1);
            if (k == 1)
                check(mem_we && mem_addr == s0 && mem_wdata == p0[15:8],
                      "R2 push pc high", {15'd0, mem_we, mem_addr, mem_wdata},
                      {15'd0, 1'b1, s0, p0[15:8]});
            if (k == 2)
                check(mem_we && mem_addr == s0 + 8'd1 && mem_wdata == p0[7:0],
                      "R2 push pc low", {15'd0, mem_we, mem_addr, mem_wdata},
                      {15'd0, 1'b1, s0 + 8'd1, p0[7:0]});
            if (k == 3)
                check(mem_we && mem_addr == s0 + 8'd2 && mem_wdata == f0,
                      "R2 push flags", {15'd0, mem_we, mem_addr, mem_wdata},
                      {15'd0, 1'b1, s0 + 8'd2, f0});
            if (k == 4) begin
                check(pc_load && pc_out == vec_pc(vec), "R3 vector pc load",
                      {15'd0, pc_load, pc_out}, {15'd0, 1'b1, vec_pc(vec)});
                check(flags_load && flags_out == 8'h00, "R3 flags cleared",
                      {23'd0, flags_load, flags_out}, {23'd0, 1'b1, 8'h00});
            end
            if (k < ENTRY) begin
                insn_done  = 1'($urandom);
                irq_req    = 1'($urandom);
                ret_strobe = 1'($urandom);
                irq_vec    = 8'($urandom);
                #1;
                check(irq_ack === 1'b0, "R9 no ack while busy", 32'(irq_ack), 32'd0);
            end else begin
                insn_done  = 1'b0;
                irq_req    = 1'b0;
                ret_strobe = 1'b0;
            end
            step();
        end
        check(busy === 1'b0, "R4 busy low in 14th cycle", 32'(busy), 32'd0);
        check(core_pc == vec_pc(vec), "R3 core pc at vector", 32'(core_pc), 32'(vec_pc(vec)));
        check(core_fl == 8'h00, "R3 enable cleared", 32'(core_fl), 32'd0);
        check(sp == s0 + 8'd3, "R2 sp up by three", 32'(sp), 32'(s0 + 8'd3));
        stk_pc[depth] = p0;
        stk_fl[depth] = f0;
        depth++;
        exp_sp = s0 + 8'd3;
    endtask

    // Return from an IDLE negedge; ends at the negedge of the resume cycle.
    task automatic run_return();
        logic [15:0] p1;
        logic [7:0]  f1;
        logic [7:0]  s0;
        depth--;
        p1 = stk_pc[depth];
        f1 = stk_fl[depth];
        s0 = exp_sp;
        ret_strobe = 1'b1;
        insn_done  = 1'b1;
        #1;
        if (irq_req && core_fl[0])
            check(irq_ack === 1'b0, "R6 return wins over request", 32'(irq_ack), 32'd0);
        step();
        ret_strobe = 1'b0;
        insn_done  = 1'b0;
        check(busy && flags_load && flags_out == f1 && mem_addr == s0 - 8'd1,
              "R5 pop flags", {14'd0, busy, flags_load, mem_addr, flags_out},
              {14'd0, 1'b1, 1'b1, s0 - 8'd1, f1});
        step();
        check(busy && !pc_load && !flags_load, "R5 pop pc low cycle",
              {29'd0, busy, pc_load, flags_load}, {29'd0, 3'b100});
        step();
        check(busy && pc_load && pc_out == p1, "R5 pop pc high",
              {14'd0, busy, pc_load, pc_out}, {14'd0, 1'b1, 1'b1, p1});
        step();
        check(busy === 1'b0, "R5 return lasts three cycles", 32'(busy), 32'd0);
        check(core_pc == p1, "R5 pc restored", 32'(core_pc), 32'(p1));
        check(core_fl == f1, "R5 flags restored", 32'(core_fl), 32'(f1));
        check(sp == s0 - 8'd3, "R5 sp down by three", 32'(sp), 32'(s0 - 8'd3));
        exp_sp = s0 - 8'd3;
    endtask

    task automatic run_all();
        logic [15:0] rp;
        logic [7:0]  rf;
        logic [7:0]  rv;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !irq_ack && !mem_we && !pc_load && !flags_load && sp == 8'h00,
              "R10 outputs during reset", {19'd0, busy, irq_ack, mem_we, pc_load, flags_load, sp},
              32'd0);
        rst_n = 1'b1;
        step();
        check(!busy && sp == 8'h00, "R10 idle after reset", {23'd0, busy, sp}, 32'd0);

        // R1 gates.
        set_core(16'h1234, 8'h80);
        irq_req   = 1'b1;
        insn_done = 1'b1;
        #1;
        check(irq_ack === 1'b0, "R1 enable clear blocks", 32'(irq_ack), 32'd0);
        step();
        check(busy === 1'b0, "R1 no entry with enable clear", 32'(busy), 32'd0);
        insn_done = 1'b0;
        irq_req   = 1'b0;
        set_core(16'h1234, 8'h81);
        irq_req = 1'b1;
        #1;
        check(irq_ack === 1'b0, "R1 no boundary blocks", 32'(irq_ack), 32'd0);
        step();
        check(busy === 1'b0, "R1 no entry without boundary", 32'(busy), 32'd0);
        irq_req = 1'b0;

        // Directed entry and return with a page-zero vector.
        run_entry(8'h04, 1'b0);
        run_return();

        // R8 nesting.
        set_core(16'hA000, 8'hC5);
        run_entry(8'h10, 1'b0);
        set_core(16'h0200, 8'h01);
        run_entry(8'h20, 1'b0);
        check(sp == 8'd6, "R8 two frames stacked", 32'(sp), 32'd6);
        run_return();
        check(core_pc == 16'h0200, "R8 inner return to handler", 32'(core_pc), 32'h0200);
        run_return();
        check(core_pc == 16'hA000, "R8 outer return to program", 32'(core_pc), 32'hA000);

        // R6 collision and R7 resume dispatch.
        set_core(16'h5555, 8'h03);
        run_entry(8'h08, 1'b0);
        set_core(16'h0310, 8'h01);
        irq_req = 1'b1;
        run_return();
        run_entry(8'h0C, 1'b0 == 1'b1 ? 1'b0 : 1'b1);
        run_return();
        step();
        irq_req = 1'b1;
        #1;
        check(irq_ack === 1'b0, "R7 resume window is one cycle", 32'(irq_ack), 32'd0);
        irq_req = 1'b0;

        // Random frames, some nested.
        for (int i = 0; i < 24; i++) begin
            rp = 16'($urandom);
            rf = with_gie(8'($urandom));
            rv = 8'($urandom);
            set_core(rp, rf);
            run_entry(rv, 1'b0);
            if (1'($urandom)) begin
                set_core(16'($urandom), with_gie(8'($urandom)));
                run_entry(8'($urandom), 1'b0);
                run_return();
            end
            run_return();
            check(core_pc == rp && core_fl == rf, "R5 random frame round trip",
                  {core_fl, 8'h00, core_pc}, {rf, 8'h00, rp});
        end
        check(sp == 8'h00, "R2 stack balanced at end", 32'(sp), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL R4 watchdog expired actual=%0d expected<%0d cycles",
                         WATCHDOG, WATCHDOG);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule